// File: doc/BRIEF.md
# Serial Potentiometer Command Front End

This block is the serial slave side of a digitally controlled potentiometer. It watches a four-wire serial bus with a pause input, all asynchronous to the system clock. It brings chip select, serial clock, serial input and pause into the system clock domain and frames the bit stream into bytes. It checks an identification byte against a fixed device-type code and two pin-strapped address bits. It then decodes an instruction byte into single-cycle command strobes for the wiper counter and the register bank that sit beside it.

A strobe carries an operation code, a register index, a bank index, a data byte and a direction flag. For read operations the neighbouring storage returns a byte on `rd_data`, and this block shifts it out on the serial output, which it enables only while it is actually driving. Commands are two bytes long (copies), three bytes long (reads and writes) or open-ended (wiper stepping), and a frame always ends when chip select rises.

Top module: `potdec_top`

## Requirements
- R1: After reset `so_en` and `cmd_valid` are low.
- R2: No frame is decoded until a high-to-low transition of `spi_cs_n` has been seen after reset. Bits clocked while chip select was already low at reset raise no strobe.
- R3: The first byte of a frame, MSB first, must be `0101`, then `00`, then a copy of `addr_strap[1:0]`. Any mismatch makes the rest of the frame be ignored: no strobe and `so_en` stays low.
- R4: The second byte is decoded as opcode in bits 7:4, register index in bits 3:2 (`cmd_reg`) and bank index in bits 1:0 (`cmd_bank`).
- R5: Opcodes `1010` (wiper write) and `1100` (register write) take a third byte, sampled MSB first on rising serial clock edges. One strobe carries it on `cmd_data`. Bits after the third byte are ignored.
- R6: Opcodes `1001` (wiper read), `1011` (register read) and `0101` with bit 0 set (status read) strobe at the end of the instruction byte with `cmd_data` = 0. `rd_data` must be valid in the cycle after the strobe. It is then shifted out on `so_d` MSB first, each bit changing on a falling serial clock edge, with `so_en` high.
- R7: Opcodes `1101` (register to wiper) and `1110` (wiper to register) strobe at the end of the instruction byte only when bank bits are `00`. With any other bank they raise no strobe.
- R8: After opcode `0010`, every following rising serial clock edge raises a step strobe with `cmd_data[0]` equal to the sampled serial input (1 = up) and `cmd_data[7:1]` = 0. This continues until chip select rises.
- R9: Any other opcode, and `0101` with bit 0 clear, raises no strobe and the rest of the frame is ignored.
- R10: While chip select is high `so_en` is low, and a frame cut short by chip select rising raises no strobe.
- R11: With `spi_hold_n` low, serial clock edges are ignored and `so_en` is low. After `spi_hold_n` returns high, shifting resumes at the same bit position.
- R12: `cmd_op` encoding: 0 wiper read, 1 wiper write, 2 register read, 3 register write, 4 register to wiper, 5 wiper to register, 6 status read, 7 step. `cmd_write` is high for codes 1, 3, 4, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause, active low |
| addr_strap | input | 2 | Pin-strapped device address |
| rd_data | input | 8 | Byte returned by storage for a read strobe |
| so_d | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for `so_d` (low = high impedance) |
| cmd_valid | output | 1 | Single-cycle command strobe |
| cmd_op | output | 3 | Operation code (R12) |
| cmd_write | output | 1 | Operation modifies storage or the wiper |
| cmd_reg | output | 2 | Register index |
| cmd_bank | output | 2 | Bank index |
| cmd_data | output | 8 | Write byte or step direction |

## Verification
The assertions assume the serial clock is slow against the system clock: each serial clock phase lasts several system cycles, so no edge is lost in the synchronizers and `rd_data` is loaded before the first falling edge of a read byte. They also assume the serial input and the pause input only move while the serial clock is low. The stimulus keeps each serial clock phase at eight system cycles, changes the serial input and the pause input only in the low phase, and moves chip select only with the serial clock low.

// File: rtl/potdec_pkg.sv
package potdec_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [3:0] DEV_TYPE = 4'b0101;

    typedef enum logic [2:0] {
        OP_RD_WIPER     = 3'd0,
        OP_WR_WIPER     = 3'd1,
        OP_RD_REG       = 3'd2,
        OP_WR_REG       = 3'd3,
        OP_REG_TO_WIPER = 3'd4,
        OP_WIPER_TO_REG = 3'd5,
        OP_RD_STATUS    = 3'd6,
        OP_STEP         = 3'd7
    } pot_op_e;

    typedef enum logic [2:0] {
        FS_IDLE, FS_ID, FS_INSTR, FS_WDATA, FS_RDATA, FS_STEP, FS_SKIP
    } frame_st_e;

    typedef enum logic [1:0] {
        TAIL_NONE, TAIL_READ, TAIL_WRITE, TAIL_STEP
    } tail_e;

    typedef struct packed {
        logic    valid;
        pot_op_e op;
        tail_e   tail;
    } instr_dec_t;

    function automatic logic id_matches(input logic [BYTE_W-1:0] b,
                                        input logic [1:0] strap);
        return (b[7:4] == DEV_TYPE) && (b[3:2] == 2'b00) && (b[1:0] == strap);
    endfunction

    function automatic instr_dec_t decode_instr(input logic [BYTE_W-1:0] b);
        instr_dec_t d;
        d.valid = 1'b1;
        d.op    = OP_RD_WIPER;
        d.tail  = TAIL_NONE;
        case (b[7:4])
            4'b1001: begin d.op = OP_RD_WIPER;     d.tail = TAIL_READ;  end
            4'b1010: begin d.op = OP_WR_WIPER;     d.tail = TAIL_WRITE; end
            4'b1011: begin d.op = OP_RD_REG;       d.tail = TAIL_READ;  end
            4'b1100: begin d.op = OP_WR_REG;       d.tail = TAIL_WRITE; end
            4'b1101: begin d.op = OP_REG_TO_WIPER; d.valid = (b[1:0] == 2'b00); end
            4'b1110: begin d.op = OP_WIPER_TO_REG; d.valid = (b[1:0] == 2'b00); end
            4'b0010: begin d.op = OP_STEP;         d.tail = TAIL_STEP;  end
            4'b0101: begin d.op = OP_RD_STATUS;    d.tail = TAIL_READ; d.valid = b[0]; end
            default: d.valid = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic op_writes(input pot_op_e op);
        return !(op == OP_RD_WIPER || op == OP_RD_REG || op == OP_RD_STATUS);
    endfunction

endpackage

// File: rtl/potdec_sync.sv
module potdec_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_async[g]};
        end
        assign d_sync[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/potdec_frame.sv
module potdec_frame
    import potdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              si_s,
    input  logic              hold_s,
    input  logic [1:0]        strap,
    output logic              cmd_valid,
    output pot_op_e           cmd_op,
    output logic [1:0]        cmd_reg,
    output logic [1:0]        cmd_bank,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              rd_phase
);
    frame_st_e         st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] sh;
    logic [BYTE_W-1:0] byte_nxt;
    logic              last_bit;
    instr_dec_t        dec;

    assign byte_nxt = {sh, si_s};
    assign last_bit = (cnt == CNT_W'(BYTE_W - 1));
    assign dec      = decode_instr(byte_nxt);
    assign rd_phase = (st == FS_RDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= FS_IDLE; cnt <= '0; sh <= '0;
            cmd_valid <= 1'b0; cmd_op <= OP_RD_WIPER;
            cmd_reg <= '0; cmd_bank <= '0; cmd_data <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (cs_s) begin
                st  <= FS_IDLE;
                cnt <= '0;
            end else if (cs_fall) begin
                st  <= FS_ID;
                cnt <= '0;
            end else if (sck_rise && hold_s && st != FS_IDLE && st != FS_SKIP) begin
                if (st == FS_STEP) begin
                    cmd_valid <= 1'b1;
                    cmd_op    <= OP_STEP;
                    cmd_data  <= {{(BYTE_W-1){1'b0}}, si_s};
                end else begin
                    sh  <= byte_nxt[BYTE_W-2:0];
                    cnt <= cnt + 1'b1;
                    if (last_bit) begin
                        case (st)
                            FS_ID: st <= id_matches(byte_nxt, strap) ? FS_INSTR : FS_SKIP;
                            FS_INSTR: begin
                                cmd_op   <= dec.op;
                                cmd_reg  <= byte_nxt[3:2];
                                cmd_bank <= byte_nxt[1:0];
                                cmd_data <= '0;
                                if (!dec.valid) st <= FS_SKIP;
                                else begin
                                    case (dec.tail)
                                        TAIL_NONE:  begin cmd_valid <= 1'b1; st <= FS_SKIP;  end
                                        TAIL_READ:  begin cmd_valid <= 1'b1; st <= FS_RDATA; end
                                        TAIL_WRITE: st <= FS_WDATA;
                                        default:    st <= FS_STEP;
                                    endcase
                                end
                            end
                            FS_WDATA: begin
                                cmd_valid <= 1'b1;
                                cmd_data  <= byte_nxt;
                                st        <= FS_SKIP;
                            end
                            default: st <= FS_SKIP;
                        endcase
                    end
                end
            end
        end
    end

    // R11: a paused bus leaves framing untouched
    a_r11_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (!hold_s && !cs_s && !cs_fall) |=> ($stable(cnt) && $stable(st)));

    // R10: every strobe comes from a selected frame
    a_r10_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(!cs_s));

    // R7: copies only touch bank zero
    a_r7_copy_bank_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == OP_REG_TO_WIPER || cmd_op == OP_WIPER_TO_REG))
        |-> (cmd_bank == 2'b00));

    // R8: step strobes carry only a direction bit
    a_r8_step_payload: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_STEP) |-> (cmd_data[BYTE_W-1:1] == '0));
endmodule

// File: rtl/potdec_sout.sv
module potdec_sout
    import potdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              active,
    input  logic              sck_fall,
    input  logic              hold_s,
    input  logic              cs_s,
    output logic              so_d,
    output logic              so_en
);
    logic [BYTE_W-1:0] sh;
    logic              started;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0; started <= 1'b0;
        end else begin
            if (load) sh <= rd_data;
            if (!active) started <= 1'b0;
            else if (sck_fall && hold_s) begin
                if (!started) started <= 1'b1;
                else          sh <= {sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign so_d  = sh[BYTE_W-1];
    assign so_en = active && started && hold_s;

    // R10: deselect turns the output driver off
    a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !so_en);
endmodule

// File: rtl/potdec_top.sv
module potdec_top
    import potdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    input  logic              spi_hold_n,
    input  logic [1:0]        addr_strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              so_d,
    output logic              so_en,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic              cmd_write,
    output logic [1:0]        cmd_reg,
    output logic [1:0]        cmd_bank,
    output logic [BYTE_W-1:0] cmd_data
);
    logic [3:0] raw_in, syn;
    logic       cs_s, sck_s, si_s, hold_s;
    logic       cs_d, sck_d, rd_pend, rd_phase;
    pot_op_e    op_q;

    assign raw_in = {spi_hold_n, spi_si, spi_sck, spi_cs_n};

    potdec_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_async(raw_in), .d_sync(syn));

    assign {hold_s, si_s, sck_s, cs_s} = syn;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d <= 1'b0; sck_d <= 1'b0; rd_pend <= 1'b0;
        end else begin
            cs_d    <= cs_s;
            sck_d   <= sck_s;
            rd_pend <= cmd_valid && !op_writes(op_q);
        end
    end

    potdec_frame u_frame (
        .clk(clk), .rst(rst), .cs_s(cs_s), .cs_fall(cs_d && !cs_s),
        .sck_rise(sck_s && !sck_d), .si_s(si_s), .hold_s(hold_s),
        .strap(addr_strap), .cmd_valid(cmd_valid), .cmd_op(op_q),
        .cmd_reg(cmd_reg), .cmd_bank(cmd_bank), .cmd_data(cmd_data),
        .rd_phase(rd_phase));

    potdec_sout u_sout (
        .clk(clk), .rst(rst), .load(rd_pend), .rd_data(rd_data),
        .active(rd_phase), .sck_fall(sck_d && !sck_s), .hold_s(hold_s),
        .cs_s(cs_s), .so_d(so_d), .so_en(so_en));

    assign cmd_op    = op_q;
    assign cmd_write = op_writes(op_q);

    // R12: write flag never accompanies a read strobe code
    a_r12_dir_flag: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd2 || cmd_op == 3'd6)) |-> !cmd_write);
endmodule

// File: tb/sim_potdec_top.sv
module sim_potdec_top;
    localparam int CLK_P = 10;
    localparam int HALF  = 8 * CLK_P;

    logic       clk = 1'b0, rst = 1'b1;
    logic       cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic [1:0] strap = 2'b10;
    logic [7:0] rd_data = 8'h00;
    logic       so_d, so_en, cmd_valid, cmd_write;
    logic [2:0] cmd_op;
    logic [1:0] cmd_reg, cmd_bank;
    logic [7:0] cmd_data;

    int checks = 0, errors = 0, strobes = 0;

    typedef struct packed {
        logic [2:0] op; logic wr; logic [1:0] rg; logic [1:0] bk; logic [7:0] data;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  got, want;
    string tag;

    always #(CLK_P/2) clk = ~clk;

    potdec_top u0 (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_hold_n(hold_n), .addr_strap(strap), .rd_data(rd_data),
        .so_d(so_d), .so_en(so_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_write(cmd_write), .cmd_reg(cmd_reg), .cmd_bank(cmd_bank),
        .cmd_data(cmd_data));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare each strobe
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            strobes++;
            got = {cmd_op, cmd_write, cmd_reg, cmd_bank, cmd_data};
            if (exp_q.size() == 0)
                chk(1'b0, "R9", "unexpected strobe", got, 0);
            else begin
                want = exp_q.pop_front();
                tag  = tag_q.pop_front();
                chk(got == want, tag, "strobe contents", got, want);
            end
        end
    end

    // reference decoder; tail 0 none, 1 read, 2 write, 3 step (R4, R12)
    function automatic void ref_dec(input logic [7:0] ins, output bit ok,
                                    output logic [2:0] op, output int tail);
        ok = 1; op = 0; tail = 0;
        case (ins[7:4])
            4'b1001: begin op = 0; tail = 1; end
            4'b1010: begin op = 1; tail = 2; end
            4'b1011: begin op = 2; tail = 1; end
            4'b1100: begin op = 3; tail = 2; end
            4'b1101: begin op = 4; ok = (ins[1:0] == 0); end
            4'b1110: begin op = 5; ok = (ins[1:0] == 0); end
            4'b0010: begin op = 7; tail = 3; end
            4'b0101: begin op = 6; tail = 1; ok = ins[0]; end
            default: ok = 0;
        endcase
    endfunction

    function automatic logic ref_wr(input logic [2:0] op);
        return !(op == 0 || op == 2 || op == 6);
    endfunction

    task automatic push(input logic [2:0] op, input logic [1:0] rg, input logic [1:0] bk,
                        input logic [7:0] d, input string req);
        exp_q.push_back({op, ref_wr(op), rg, bk, d});
        tag_q.push_back(req);
    endtask

    task automatic sbit(input logic b, output logic so_s, output logic en_s);
        si = b;
        #(HALF);
        so_s = so_d; en_s = so_en;
        sck = 1'b1;
        #(HALF);
        sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output int en_cnt);
        logic s, e;
        en_cnt = 0;
        for (int i = 7; i >= 0; i--) begin
            sbit(tx[i], s, e);
            rx[i] = s;
            if (e) en_cnt++;
        end
    endtask

    task automatic frame_start;
        cs_n = 1'b0;
        #(HALF);
    endtask

    task automatic frame_end(input string req);
        #(HALF);
        cs_n = 1'b1;
        #(4 * HALF);
        chk(exp_q.size() == 0, req, "missing strobe count", exp_q.size(), 0);
        chk(so_en == 1'b0, "R10", "so_en while deselected", so_en, 0);
        exp_q.delete(); tag_q.delete();
    endtask

    task automatic run_cmd(input logic [7:0] id, input logic [7:0] ins,
                           input logic [7:0] data, input logic [7:0] rdv, input string req);
        bit ok; logic [2:0] op; int tail, en; logic [7:0] rx;
        ref_dec(ins, ok, op, tail);
        if (id != {4'b0101, 2'b00, strap}) ok = 0;
        rd_data = rdv;
        if (ok) begin
            if (tail == 3)
                for (int i = 7; i >= 0; i--) push(3'd7, 2'b00, 2'b00, {7'b0, data[i]}, req);
            else
                push(op, ins[3:2], ins[1:0], (tail == 2) ? data : 8'h00, req);
        end
        frame_start;
        xbyte(id, rx, en);
        xbyte(ins, rx, en);
        xbyte(data, rx, en);
        if (ok && tail == 1) begin
            chk(en == 8, req, "so_en bit count", en, 8);
            chk(rx == rdv, req, "serial read byte", rx, rdv);
        end else
            chk(en == 0, req, "so_en bit count", en, 0);
        if (ok && tail != 3) begin
            xbyte(8'hFF, rx, en);   // R5: trailing bits ignored
        end
        frame_end(req);
    endtask

    initial begin
        #(100000 * CLK_P);
        chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rx; int en; logic s, e;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(so_en == 1'b0 && cmd_valid == 1'b0, "R1", "outputs after reset",
            {so_en, cmd_valid}, 0);

        // R2: chip select low since reset, never fell
        xbyte(8'h52, rx, en); xbyte(8'hA0, rx, en); xbyte(8'h11, rx, en);
        #(HALF);
        chk(strobes == 0, "R2", "strobes before first select edge", strobes, 0);
        cs_n = 1'b1;
        #(4 * HALF);

        run_cmd(8'h52, 8'hA0, 8'hA5, 8'h00, "R5");   // wiper write
        run_cmd(8'h52, 8'hCB, 8'h3C, 8'h00, "R4");   // reg write bank 3 reg 2
        run_cmd(8'h52, 8'hC4, 8'h81, 8'h00, "R12");
        run_cmd(8'h52, 8'h90, 8'h00, 8'hC3, "R6");   // wiper read
        run_cmd(8'h52, 8'hB6, 8'h00, 8'h7E, "R6");   // reg read
        run_cmd(8'h52, 8'h51, 8'h00, 8'h01, "R6");   // status read
        run_cmd(8'h52, 8'h50, 8'h00, 8'hAA, "R9");   // status with P0 clear
        run_cmd(8'h52, 8'hDC, 8'h00, 8'h00, "R7");
        run_cmd(8'h52, 8'hE4, 8'h00, 8'h00, "R7");
        run_cmd(8'h52, 8'hD1, 8'h00, 8'h00, "R7");   // bank 1: none
        run_cmd(8'h52, 8'hE2, 8'h00, 8'h00, "R7");   // bank 2: none
        run_cmd(8'h52, 8'h00, 8'h55, 8'h00, "R9");
        run_cmd(8'h52, 8'hF3, 8'h55, 8'h00, "R9");
        run_cmd(8'h52, 8'h30, 8'h55, 8'h00, "R9");
        run_cmd(8'h51, 8'hA0, 8'h12, 8'h00, "R3");   // strap mismatch
        run_cmd(8'h72, 8'hA0, 8'h12, 8'h00, "R3");   // wrong type code
        run_cmd(8'h5A, 8'h90, 8'h00, 8'hFF, "R3");   // nonzero fixed bits
        run_cmd(8'h52, 8'h20, 8'hB4, 8'h00, "R8");   // step sequence
        strap = 2'b01;
        run_cmd(8'h51, 8'hA0, 8'h6D, 8'h00, "R3");
        strap = 2'b10;

        // R10: abort mid data byte
        frame_start;
        xbyte(8'h52, rx, en); xbyte(8'hA0, rx, en);
        for (int i = 0; i < 4; i++) sbit(1'b1, s, e);
        frame_end("R10");
        run_cmd(8'h52, 8'hA0, 8'h0F, 8'h00, "R10");

        // R11: pause inside a write data byte
        push(3'd3, 2'b10, 2'b01, 8'h96, "R11");
        frame_start;
        xbyte(8'h52, rx, en); xbyte(8'hC9, rx, en);
        for (int i = 7; i >= 4; i--) sbit(((8'h96 >> i) & 1) != 0, s, e);
        hold_n = 1'b0;
        #(HALF);
        for (int i = 0; i < 3; i++) sbit(1'b1, s, e);
        hold_n = 1'b1;
        #(HALF);
        for (int i = 3; i >= 0; i--) sbit(((8'h96 >> i) & 1) != 0, s, e);
        frame_end("R11");

        // R11: pause inside a read byte
        rd_data = 8'h5A;
        push(3'd2, 2'b01, 2'b11, 8'h00, "R11");
        frame_start;
        xbyte(8'h52, rx, en); xbyte(8'hB7, rx, en);
        for (int i = 7; i >= 5; i--) begin sbit(1'b0, s, e); rx[i] = s; end
        hold_n = 1'b0;
        #(HALF);
        chk(so_en == 1'b0, "R11", "so_en during pause", so_en, 0);
        sbit(1'b0, s, e);
        hold_n = 1'b1;
        #(HALF);
        for (int i = 4; i >= 0; i--) begin sbit(1'b0, s, e); rx[i] = s; end
        chk(rx == 8'h5A, "R11", "read byte across pause", rx, 8'h5A);
        frame_end("R11");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule